// File: doc/BRIEF.md
# Three-Wire Radio Register Serial Master

This block is the host side of a three-wire serial link used to program the configuration registers of a radio front end. It drives an enable line, a serial clock and a data line, plus a separate read/write direction line. A register write carries a 4-bit register number and 12 bits of payload. A register read sends a 5-bit register number, hands the data line over to the radio, and clocks 12 bits back.

The surrounding logic raises a one-cycle request with the operation type, address and write payload while `busy` is low. The block answers with a one-cycle `done` and, for reads, the captured value on `rdData`. All bit timing is built from a timing slot of `SLOT_CLKS` system clocks, so one design serves any system clock rate. The data line is split into a driven value, an output enable and an input, so that the pad can be built outside the block.

Top module: `rf_serial_master`

## Requirements
- R1: After reset, `wireEn`=1, `wireClk`=0, `wireRw`=0, `wireDataOut`=0, `wireDataOe`=1, `busy`=0, `done`=0 and `rdData`=0.
- R2: A request (`reqValid`=1) is taken only while `busy` is 0. `busy` is 1 from the cycle after acceptance until `done` has pulsed for exactly one cycle, and it is 0 in the cycle after `done`. A request raised while `busy` is 1 is ignored and leaves the transfer unchanged.
- R3: A write (`reqRead`=0) shifts out 16 bits, most significant first, on rising edges of `wireClk`. The frame is `reqData` in bits 15:4 and `reqAddr[3:0]` in bits 3:0.
- R4: `wireEn` stays 1 for one slot after acceptance and reads 0 from sample SLOT_CLKS+2 onward, counting the cycle after acceptance as sample 1. It stays 0 at every rising edge of `wireClk` and is 1 again when `done` pulses.
- R5: Each outgoing bit is set up while `wireClk` is low. `wireClk` is then high for 2 slots, and `wireDataOut` does not change while the clock is high.
- R6: A read (`reqRead`=1) first shifts out `reqAddr[4:0]` on 5 rising edges, most significant first, with `wireRw`=0 at each of those edges.
- R7: After the fifth address bit, `wireRw` rises while `wireClk` is still high. `wireDataOe` then falls with `wireClk` low and `wireRw` high. While `wireDataOe` is 0, `wireRw` is 1.
- R8: The read phase has 12 rising edges of `wireClk`, each followed by a high interval of 3 slots. The block samples `wireDataIn` at the end of each high interval and fills `rdData` most significant bit first. `rdData` holds the result when `done` pulses.
- R9: When `done` pulses after a read, `wireEn`=1, `wireRw`=1, `wireDataOe`=1 and `wireClk`=0. After a write, `wireRw` is 0 at that point.
- R10: Every interval between wire transitions is a whole number of slots of `SLOT_CLKS` clocks. The last address bit of a read holds the clock high for 3 slots (2 for the bit, 1 for the direction switch).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when `busy` is 0 |
| reqRead | input | 1 | 1 = register read, 0 = register write |
| reqAddr | input | 5 | Register number (low 4 bits used for writes) |
| reqData | input | 12 | Write payload |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 12 | Value captured by the last read |
| wireEn | output | 1 | Serial enable, low during a transfer |
| wireClk | output | 1 | Serial clock |
| wireRw | output | 1 | Direction line, high while the radio drives data |
| wireDataOut | output | 1 | Value driven onto the data line |
| wireDataOe | output | 1 | Data line output enable |
| wireDataIn | input | 1 | Value read from the data line |

## Verification
Writes and reads are mixed in random order with random addresses, payloads and returned values. A model of the radio in the bench decodes the wires, captures each outgoing frame at the clock rising edges, drives reply bits after the falling edges and times every clock-high run. The directed cases use all-ones and all-zeros payloads and returned values, the highest and lowest read addresses, and an alternating pattern. These separate nibble or bit-order errors from stuck bits and show an off-by-one in the bit counts. One directed transfer raises a second request in mid-flight, which shows whether a request made while busy corrupts the frame or adds a completion.

// File: rtl/rf_serial_pkg.sv
package rf_serial_pkg;

  // Per-cycle commands from the sequencer to the datapath
  typedef struct packed {
    logic load;      // capture request into the shift register
    logic isRead;    // request type presented with load
    logic shiftTx;   // advance outgoing shift register
    logic sampleRx;  // capture one incoming bit
    logic enLvl;     // level for the enable line
    logic clkLvl;    // level for the serial clock
    logic rwLvl;     // level for the direction line
    logic oeLvl;     // data line output enable
    logic drvBit;    // drive shift-register MSB (else 0)
  } wireStrobe_t;

endpackage

// File: rtl/rf_serial_ctrl.sv
module rf_serial_ctrl
  import rf_serial_pkg::*;
#(
  parameter int SLOT_CLKS     = 4,
  parameter int FRAME_W       = 16,
  parameter int RD_ADDR_W     = 5,
  parameter int RD_DATA_W     = 12,
  parameter int WR_HIGH_SLOTS = 2,
  parameter int RD_HIGH_SLOTS = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqRead,
  output logic        busy,
  output logic        done,
  output wireStrobe_t strb
);

  localparam int SLOT_W = $clog2(SLOT_CLKS + 1);
  localparam int SUB_W  = $clog2(RD_HIGH_SLOTS + 1);
  localparam int BIT_W  = $clog2(FRAME_W + RD_DATA_W + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ENLOW, S_ASETUP, S_AHIGH,
    S_RWSET, S_TURN, S_DLOW, S_DHIGH, S_FINISH
  } phase_t;

  phase_t            state;
  logic [SLOT_W-1:0] slotCnt;
  logic [SUB_W-1:0]  subCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              isReadQ;
  logic              slotTick;
  logic              wrSubLast;
  logic              rdSubLast;

  assign slotTick  = (slotCnt == SLOT_W'(SLOT_CLKS - 1));
  assign wrSubLast = (subCnt == SUB_W'(WR_HIGH_SLOTS - 1));
  assign rdSubLast = (subCnt == SUB_W'(RD_HIGH_SLOTS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      slotCnt <= '0;
      subCnt  <= '0;
      bitCnt  <= '0;
      isReadQ <= 1'b0;
    end else if (state == S_IDLE) begin
      slotCnt <= '0;
      if (reqValid) begin
        state   <= S_START;
        isReadQ <= reqRead;
      end
    end else begin
      slotCnt <= slotTick ? '0 : slotCnt + 1'b1;
      if (slotTick) begin
        case (state)
          S_START: state <= S_ENLOW;
          S_ENLOW: begin
            state  <= S_ASETUP;
            bitCnt <= isReadQ ? BIT_W'(RD_ADDR_W - 1) : BIT_W'(FRAME_W - 1);
          end
          S_ASETUP: begin
            state  <= S_AHIGH;
            subCnt <= '0;
          end
          S_AHIGH: begin
            if (wrSubLast) begin
              if (bitCnt == '0) begin
                state <= isReadQ ? S_RWSET : S_FINISH;
              end else begin
                bitCnt <= bitCnt - 1'b1;
                state  <= S_ASETUP;
              end
            end else begin
              subCnt <= subCnt + 1'b1;
            end
          end
          S_RWSET: state <= S_TURN;
          S_TURN: begin
            state  <= S_DLOW;
            bitCnt <= BIT_W'(RD_DATA_W - 1);
          end
          S_DLOW: begin
            state  <= S_DHIGH;
            subCnt <= '0;
          end
          S_DHIGH: begin
            if (rdSubLast) begin
              if (bitCnt == '0) begin
                state <= S_FINISH;
              end else begin
                bitCnt <= bitCnt - 1'b1;
                state  <= S_DLOW;
              end
            end else begin
              subCnt <= subCnt + 1'b1;
            end
          end
          S_FINISH: state <= S_IDLE;
          default:  state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.enLvl    = 1'b1;
    strb.oeLvl    = 1'b1;
    strb.load     = (state == S_IDLE) && reqValid;
    strb.isRead   = reqRead;
    strb.shiftTx  = (state == S_AHIGH) && slotTick && wrSubLast && (bitCnt != '0);
    strb.sampleRx = (state == S_DHIGH) && slotTick && rdSubLast;
    case (state)
      S_ENLOW:  strb.enLvl = 1'b0;
      S_ASETUP: begin strb.enLvl = 1'b0; strb.drvBit = 1'b1; end
      S_AHIGH:  begin strb.enLvl = 1'b0; strb.drvBit = 1'b1; strb.clkLvl = 1'b1; end
      S_RWSET:  begin
        strb.enLvl = 1'b0; strb.drvBit = 1'b1; strb.clkLvl = 1'b1; strb.rwLvl = 1'b1;
      end
      S_TURN, S_DLOW: begin strb.enLvl = 1'b0; strb.rwLvl = 1'b1; strb.oeLvl = 1'b0; end
      S_DHIGH:  begin
        strb.enLvl = 1'b0; strb.rwLvl = 1'b1; strb.oeLvl = 1'b0; strb.clkLvl = 1'b1;
      end
      S_FINISH: strb.rwLvl = isReadQ;
      default:  ;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FINISH) && slotTick;

  // R2: completion returns the block to idle on the next cycle
  p_done_ends_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  // R2: an idle block always takes a request
  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);
  // R10: slot counter never passes the slot length
  p_slot_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    slotCnt < SLOT_W'(SLOT_CLKS));

endmodule

// File: rtl/rf_serial_dp.sv
module rf_serial_dp
  import rf_serial_pkg::*;
#(
  parameter int WR_ADDR_W = 4,
  parameter int WR_DATA_W = 12,
  parameter int RD_ADDR_W = 5,
  parameter int RD_DATA_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wireStrobe_t          strb,
  input  logic [RD_ADDR_W-1:0] reqAddr,
  input  logic [WR_DATA_W-1:0] reqData,
  input  logic                 wireDataIn,
  output logic                 wireEn,
  output logic                 wireClk,
  output logic                 wireRw,
  output logic                 wireDataOut,
  output logic                 wireDataOe,
  output logic [RD_DATA_W-1:0] rdData
);

  localparam int FRAME_W = WR_DATA_W + WR_ADDR_W;
  localparam int PAD_W   = FRAME_W - RD_ADDR_W;

  logic [FRAME_W-1:0]   txShift;
  logic [RD_DATA_W-1:0] rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strb.load) begin
      txShift <= strb.isRead ? {reqAddr, {PAD_W{1'b0}}}
                             : {reqData, reqAddr[WR_ADDR_W-1:0]};
    end else if (strb.shiftTx) begin
      txShift <= {txShift[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (strb.sampleRx) begin
      rxShift <= {rxShift[RD_DATA_W-2:0], wireDataIn};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wireEn      <= 1'b1;
      wireClk     <= 1'b0;
      wireRw      <= 1'b0;
      wireDataOut <= 1'b0;
      wireDataOe  <= 1'b1;
    end else begin
      wireEn      <= strb.enLvl;
      wireClk     <= strb.clkLvl;
      wireRw      <= strb.rwLvl;
      wireDataOut <= strb.drvBit & txShift[FRAME_W-1];
      wireDataOe  <= strb.oeLvl;
    end
  end

  assign rdData = rxShift;

  // R5: data held while the serial clock stays high
  p_data_stable_hi_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wireClk && $past(wireClk)) |-> $stable(wireDataOut));
  // R7: data line released only with direction set to read
  p_release_rw_r7: assert property (@(posedge clk) disable iff (!rstN)
    !wireDataOe |-> wireRw);
  // R7: release happens with the clock low
  p_release_clk_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wireDataOe) |-> !wireClk);
  // R4: clock pulses only inside an enable-low window
  p_en_low_clk_r4: assert property (@(posedge clk) disable iff (!rstN)
    wireClk |-> !wireEn);

endmodule

// File: rtl/rf_serial_master.sv
module rf_serial_master
  import rf_serial_pkg::*;
#(
  parameter int SLOT_CLKS = 4,
  parameter int WR_ADDR_W = 4,
  parameter int WR_DATA_W = 12,
  parameter int RD_ADDR_W = 5,
  parameter int RD_DATA_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqRead,
  input  logic [RD_ADDR_W-1:0] reqAddr,
  input  logic [WR_DATA_W-1:0] reqData,
  output logic                 busy,
  output logic                 done,
  output logic [RD_DATA_W-1:0] rdData,
  output logic                 wireEn,
  output logic                 wireClk,
  output logic                 wireRw,
  output logic                 wireDataOut,
  output logic                 wireDataOe,
  input  logic                 wireDataIn
);

  localparam int FRAME_W = WR_DATA_W + WR_ADDR_W;

  wireStrobe_t strb;

  rf_serial_ctrl #(
    .SLOT_CLKS    (SLOT_CLKS),
    .FRAME_W      (FRAME_W),
    .RD_ADDR_W    (RD_ADDR_W),
    .RD_DATA_W    (RD_DATA_W),
    .WR_HIGH_SLOTS(2),
    .RD_HIGH_SLOTS(3)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqRead (reqRead),
    .busy    (busy),
    .done    (done),
    .strb    (strb)
  );

  rf_serial_dp #(
    .WR_ADDR_W(WR_ADDR_W),
    .WR_DATA_W(WR_DATA_W),
    .RD_ADDR_W(RD_ADDR_W),
    .RD_DATA_W(RD_DATA_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .wireDataIn (wireDataIn),
    .wireEn     (wireEn),
    .wireClk    (wireClk),
    .wireRw     (wireRw),
    .wireDataOut(wireDataOut),
    .wireDataOe (wireDataOe),
    .rdData     (rdData)
  );

endmodule

// File: tb/rf_serial_master_test.sv
`timescale 1ns/1ps
module rf_serial_master_test;

  localparam int SLOT = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqRead = 1'b0;
  logic [4:0]  reqAddr = '0;
  logic [11:0] reqData = '0;
  logic        busy, done;
  logic [11:0] rdData;
  logic        wireEn, wireClk, wireRw, wireDataOut, wireDataOe;
  logic        wireDataIn = 1'b0;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  rf_serial_master uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .reqAddr(reqAddr), .reqData(reqData), .busy(busy), .done(done),
    .rdData(rdData), .wireEn(wireEn), .wireClk(wireClk), .wireRw(wireRw),
    .wireDataOut(wireDataOut), .wireDataOe(wireDataOe), .wireDataIn(wireDataIn)
  );

  function automatic logic [15:0] expFrame(input logic [4:0] a, input logic [11:0] d);
    return {d, a[3:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  // One transfer with the bench acting as the radio
  task automatic runTxn(input logic isRd, input logic [4:0] addr, input logic [11:0] wdat,
                        input logic [11:0] devDat, input bit pokeBusy);
    int n = 0, firstEnLow = 0, capN = 0, rdRise = 0, hiRun = 0;
    int hiBad = 0, stableBad = 0, rwBad = 0, enBad = 0, doneCnt = 0, devIdx = -1;
    int rwRiseBad = 0, oeFallBad = 0, doneBad = 0, postDone = 0, busyBad = 0;
    logic [15:0] cap = '0;
    logic pClk = 1'b0, pOe = 1'b1, pRw = 1'b0, pDat = 1'b0, rdRun = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqRead = isRd; reqAddr = addr; reqData = wdat;
    while (postDone < 3 && n < 2000) begin
      @(negedge clk);
      n++;
      if (n == 1) reqValid = 1'b0;
      if (pokeBusy && n == 6) begin
        reqValid = 1'b1; reqRead = ~isRd; reqAddr = ~addr; reqData = ~wdat;
      end
      if (pokeBusy && n == 7) reqValid = 1'b0;
      if (n == 1) chk(busy == 1'b1, "R2 busy after accept", busy, 1);
      if (!wireEn && firstEnLow == 0) firstEnLow = n;
      if (wireClk && !pClk) begin
        if (wireEn) enBad++;
        hiRun = 1;
        if (wireDataOe) begin
          cap = {cap[14:0], wireDataOut}; capN++;
          if (wireRw) rwBad++;
          rdRun = 1'b0;
        end else begin
          rdRise++; rdRun = 1'b1;
        end
      end else if (wireClk && pClk) begin
        hiRun++;
        if (wireDataOut != pDat) stableBad++;
      end
      if (!wireClk && pClk) begin
        if (rdRun || (isRd && capN == 5)) begin
          if (hiRun != 3*SLOT) hiBad++;
        end else if (hiRun != 2*SLOT) hiBad++;
        if (!wireDataOe && devIdx >= 0) begin
          wireDataIn = devDat[devIdx]; devIdx--;
        end
      end
      if (wireRw && !pRw && !wireClk) rwRiseBad++;
      if (!wireDataOe && pOe) begin
        if (wireClk || !wireRw) oeFallBad++;
        wireDataIn = devDat[11]; devIdx = 10;
      end
      if (done) begin
        doneCnt++;
        if (!wireEn || !wireDataOe || wireClk || wireRw != isRd) doneBad++;
        if (isRd) chk(rdData == devDat, "R8 read data at done", rdData, devDat);
      end
      if (doneCnt > 0 && !done) begin
        postDone++;
        if (busy) busyBad++;
      end
      pClk = wireClk; pOe = wireDataOe; pRw = wireRw; pDat = wireDataOut;
    end
    chk(doneCnt == 1, "R2 single done pulse", doneCnt, 1);
    chk(busyBad == 0, "R2 busy low after done", busyBad, 0);
    chk(firstEnLow == SLOT + 2, "R4 enable low timing", firstEnLow, SLOT + 2);
    chk(enBad == 0, "R4 enable low at clock edges", enBad, 0);
    chk(stableBad == 0, "R5 data stable while clock high", stableBad, 0);
    chk(hiBad == 0, "R10 clock high lengths", hiBad, 0);
    if (isRd) begin
      chk(capN == 5, "R6 address bit count", capN, 5);
      chk(cap[4:0] == addr, "R6 read address", cap[4:0], addr);
      chk(rwBad == 0, "R6 rw low on address bits", rwBad, 0);
      chk(rwRiseBad == 0, "R7 rw rises with clock high", rwRiseBad, 0);
      chk(oeFallBad == 0, "R7 release with clock low rw high", oeFallBad, 0);
      chk(rdRise == 12, "R8 read bit count", rdRise, 12);
      chk(doneBad == 0, "R9 lines after read", doneBad, 0);
    end else begin
      chk(capN == 16, "R3 write bit count", capN, 16);
      chk(cap == expFrame(addr, wdat), "R3 write frame", cap, expFrame(addr, wdat));
      chk(rwBad == 0, "R9 rw low during write", rwBad, 0);
      chk(doneBad == 0, "R9 lines after write", doneBad, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL R2 watchdog expired actual=0x0 expected=0x1");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(wireEn == 1'b1 && wireClk == 1'b0 && wireRw == 1'b0, "R1 control lines",
        {wireEn, wireClk, wireRw}, 3'b100);
    chk(wireDataOut == 1'b0 && wireDataOe == 1'b1, "R1 data line", {wireDataOut, wireDataOe}, 2'b01);
    chk(busy == 1'b0 && done == 1'b0 && rdData == 12'h0, "R1 handshake", {busy, done, rdData}, 0);
    // directed corners
    runTxn(1'b0, 5'h0f, 12'hfff, 12'h000, 1'b0);
    runTxn(1'b0, 5'h00, 12'h000, 12'h000, 1'b0);
    runTxn(1'b1, 5'h1f, 12'h000, 12'hfff, 1'b0);
    runTxn(1'b1, 5'h00, 12'h000, 12'h000, 1'b0);
    runTxn(1'b1, 5'h15, 12'h000, 12'ha5a, 1'b1);
    runTxn(1'b0, 5'h06, 12'h5a3, 12'h000, 1'b1);
    // random mix
    for (int i = 0; i < 40; i++) begin
      runTxn(1'($urandom_range(0, 1)), 5'($urandom), 12'($urandom), 12'($urandom), 1'b0);
    end
    summary();
    $finish;
  end

endmodule